// File: doc/BRIEF.md
# Write-Path Width Adapter FIFO

This block is the write-data front end of a high-throughput memory port. It takes write addresses and write data beats from a master. The master is either 64 bits wide, or 32 bits wide with its beats on the low half of the data bus. Each beat lands in a 64-bit-wide data FIFO that a downstream consumer drains through a plain valid/ready pop interface. When the master is 32 bits wide, each burst's attributes decide how its beats go in. They are either packed in pairs into full 64-bit entries (upsizing) or placed one per entry in the half that the beat address selects (expansion).

Accepted addresses wait in a small command queue until their data has been consumed and their write response has been returned. The response is OKAY, or a decode error for a non-secure write presented to a port configured as secure. The FIFO fill level is driven out continuously, so the master can pace itself against it.

Top module: `wr_width_adapt`

## Requirements
- R1: With `cfg_narrow`=0, `w_ready` is 1 exactly when `fifo_count` is below FIFO_DEPTH (128), whether or not any address has been accepted.
- R2: With `cfg_narrow`=1, `w_ready` is 1 only when `fifo_count` is below FIFO_DEPTH and the address of the burst the next beat belongs to was accepted in an earlier cycle. An address accepted in the same cycle as its first beat costs exactly one wait cycle; an address accepted at least one cycle earlier costs none.
- R3: In 32-bit mode with `aw_cache` bit 1 set, the half of beat k is `aw_addr` bit 2 XOR (k mod 2), where half 1 is bits 63:32 and half 0 is bits 31:0. A half-0 beat that is not last is held back. A half-1 beat pushes one entry, with the held beat (if any) in the low half and itself in the high half. A last beat in half 0 pushes alone. A half with no beat has zero data and zero strobes.
- R4: In 32-bit mode with `aw_cache` bit 1 clear, every beat pushes its own entry. The beat's `w_data[31:0]` and `w_strb[3:0]` go into the half given by the rule of R3, and the other half is zero in both data and strobes. `w_data[63:32]` and `w_strb[7:4]` are ignored.
- R5: `fifo_count` equals the number of stored entries and changes by push minus pop each cycle. Entries leave on `pop_valid && pop_ready` in push order. `pop_valid` is 1 whenever the count is non-zero.
- R6: One response is given per burst, in address order, once its address has been accepted and its last beat taken. `b_resp` is 2'b11 when `cfg_secure`=1 and `aw_prot` bit 1 = 1, and 2'b00 otherwise. `b_valid` and `b_resp` hold until `b_ready`.
- R7: A beat of a refused burst (R6 decode error) that is accepted after its address is pushed with all eight strobes zero.
- R8: `aw_ready` is 0 while CQ_DEPTH (4) addresses are held, an address being released when its response is taken.
- R9: After reset `fifo_count`=0, `pop_valid`=0, `b_valid`=0 and `aw_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_narrow | input | 1 | 1: master is 32 bits wide |
| cfg_secure | input | 1 | 1: port refuses non-secure writes |
| aw_valid | input | 1 | Address valid |
| aw_ready | output | 1 | Address accepted |
| aw_addr | input | 32 | Burst start address |
| aw_len | input | 4 | Beats minus one |
| aw_cache | input | 4 | Cache attributes; bit 1 enables packing |
| aw_prot | input | 3 | Protection; bit 1 marks non-secure |
| w_valid | input | 1 | Data beat valid |
| w_ready | output | 1 | Data beat accepted |
| w_data | input | 64 | Beat data |
| w_strb | input | 8 | Beat byte strobes |
| w_last | input | 1 | Last beat of burst |
| b_valid | output | 1 | Response valid |
| b_ready | input | 1 | Response taken |
| b_resp | output | 2 | 2'b00 OKAY, 2'b11 decode error |
| fifo_count | output | 8 | Entries in the data FIFO |
| pop_valid | output | 1 | FIFO head valid |
| pop_ready | input | 1 | Consumer takes head |
| pop_data | output | 64 | FIFO head data |
| pop_strb | output | 8 | FIFO head strobes |

## Verification
Several of the block's functions can fall in the same cycle. The address of a new burst can be accepted in the same cycle as the first 32-bit beat of that burst, while a packed entry is pushed and the consumer pops another. A response can also be released in the cycle that a further burst's last beat is counted. The bench provokes these overlaps by queueing address and data with independent delays (zero for both, to force the coincidence) and by driving `pop_ready` and `b_ready` from a pseudo-random bit. A behavioural queue model is compared every clock on `w_ready`, `aw_ready`, `fifo_count`, the FIFO head and the response, so a lost or doubled push, a missed wait cycle or a miscounted response is caught in the cycle it happens.

// File: rtl/wa_pkg.sv
package wa_pkg;
  localparam int unsigned LEN_W = 4;
  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_DECERR = 2'b11;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             start_hi;
    logic             pack;
    logic             reject;
  } wa_cmd_t;

  // half of the 64-bit entry that beat idx of a burst occupies
  function automatic logic beat_half(input logic start_hi, input logic [LEN_W-1:0] idx);
    return start_hi ^ idx[0];
  endfunction

  function automatic logic refuse(input logic secure_port, input logic [2:0] prot);
    return secure_port & prot[1];
  endfunction

  function automatic logic [1:0] resp_for(input logic rej);
    return rej ? RESP_DECERR : RESP_OKAY;
  endfunction
endpackage

// File: rtl/wa_cmd_queue.sv
module wa_cmd_queue
  import wa_pkg::*;
#(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned DCNT_W = 8
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    push,
  input  wa_cmd_t push_cmd,
  input  logic    data_done,
  input  logic    resp_pop,
  output logic    full,
  output logic    cur_known,
  output wa_cmd_t cur_cmd,
  output logic    resp_avail,
  output wa_cmd_t head_cmd
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned NUM_W = $clog2(DEPTH + 1);

  wa_cmd_t            slots [DEPTH];
  logic [PTR_W-1:0]   wr_ptr, rd_ptr, cur_idx;
  logic [NUM_W-1:0]   n_cmd;
  logic [DCNT_W-1:0]  dcnt;    // bursts whose data is complete, not yet responded
  logic [DCNT_W-1:0]  n_wide;

  assign n_wide     = DCNT_W'(n_cmd);
  assign full       = (n_cmd == NUM_W'(DEPTH));
  assign cur_known  = (dcnt < n_wide);
  assign cur_idx    = rd_ptr + dcnt[PTR_W-1:0];
  assign cur_cmd    = slots[cur_idx];
  assign head_cmd   = slots[rd_ptr];
  assign resp_avail = (n_cmd != '0) && (dcnt != '0);

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= push_cmd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      n_cmd  <= '0;
      dcnt   <= '0;
    end else begin
      if (push)     wr_ptr <= wr_ptr + 1'b1;
      if (resp_pop) rd_ptr <= rd_ptr + 1'b1;
      n_cmd <= n_cmd + NUM_W'(push) - NUM_W'(resp_pop);
      dcnt  <= dcnt + DCNT_W'(data_done) - DCNT_W'(resp_pop);
    end
  end

  AST_CQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);  // R8
  AST_RESP_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    resp_pop |-> (n_cmd != '0) && (dcnt != '0));  // R6
  AST_DCNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    data_done |-> (dcnt != '1));  // R6
endmodule

// File: rtl/wa_beat_packer.sv
module wa_beat_packer
  import wa_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                narrow,
  input  logic                beat_fire,
  input  logic [DATA_W-1:0]   w_data,
  input  logic [DATA_W/8-1:0] w_strb,
  input  logic                w_last,
  input  logic                cur_known,
  input  wa_cmd_t             cur_cmd,
  output logic                push,
  output logic [DATA_W-1:0]   push_data,
  output logic [DATA_W/8-1:0] push_strb
);
  localparam int unsigned HALF_W  = DATA_W / 2;
  localparam int unsigned STRB_W  = DATA_W / 8;
  localparam int unsigned HSTRB_W = STRB_W / 2;

  logic [LEN_W-1:0]   bidx;
  logic [HALF_W-1:0]  hold_d;
  logic [HSTRB_W-1:0] hold_s;
  logic               hold_v;

  // named internal events
  logic               in_hi;    // beat belongs to the upper half
  logic               park;     // beat is held for pairing, nothing pushed
  logic               kill;     // burst is refused: strobes cleared
  logic [HALF_W-1:0]  lo_d, prev_d;
  logic [HSTRB_W-1:0] lo_s, prev_s;
  logic               unused_len;

  assign unused_len = ^cur_cmd.len;
  assign in_hi  = beat_half(cur_cmd.start_hi, bidx);
  assign lo_d   = w_data[HALF_W-1:0];
  assign lo_s   = w_strb[HSTRB_W-1:0];
  assign prev_d = (hold_v && cur_cmd.pack) ? hold_d : '0;
  assign prev_s = (hold_v && cur_cmd.pack) ? hold_s : '0;
  assign park   = narrow && cur_cmd.pack && !in_hi && !w_last;
  assign kill   = cur_known && cur_cmd.reject;

  always_comb begin
    push = beat_fire && !park;
    if (!narrow) begin
      push_data = w_data;
      push_strb = w_strb;
    end else if (in_hi) begin
      push_data = {lo_d, prev_d};
      push_strb = {lo_s, prev_s};
    end else begin
      push_data = {{HALF_W{1'b0}}, lo_d};
      push_strb = {{HSTRB_W{1'b0}}, lo_s};
    end
    if (kill) push_strb = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bidx   <= '0;
      hold_v <= 1'b0;
      hold_d <= '0;
      hold_s <= '0;
    end else if (beat_fire) begin
      bidx   <= w_last ? '0 : bidx + 1'b1;
      hold_v <= park;
      if (park) begin
        hold_d <= lo_d;
        hold_s <= lo_s;
      end
    end
  end

  AST_HOLD_EMPTY_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && narrow && bidx == '0) |-> !hold_v);  // R3
  AST_EXPAND_ONE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (push && narrow && !cur_cmd.pack) |->
      (push_strb[STRB_W-1:HSTRB_W] == '0 || push_strb[HSTRB_W-1:0] == '0));  // R4
  AST_NARROW_HAS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && narrow) |-> cur_known);  // R2
endmodule

// File: rtl/wa_data_fifo.sv
module wa_data_fifo #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned DW    = 64,
  parameter int unsigned SW    = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [DW-1:0]    push_data,
  input  logic [SW-1:0]    push_strb,
  input  logic             pop_ready,
  output logic             pop_valid,
  output logic [DW-1:0]    pop_data,
  output logic [SW-1:0]    pop_strb,
  output logic [CNT_W-1:0] count
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic [DW-1:0]    mem_d [DEPTH];
  logic [SW-1:0]    mem_s [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             pop;

  assign pop_valid = (count != '0);
  assign pop       = pop_valid && pop_ready;
  assign pop_data  = mem_d[rd_ptr];
  assign pop_strb  = mem_s[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) begin
      mem_d[wr_ptr] <= push_data;
      mem_s[wr_ptr] <= push_strb;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < CNT_W'(DEPTH)));  // R1
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));  // R5
endmodule

// File: rtl/wr_width_adapt.sv
module wr_width_adapt
  import wa_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned FIFO_DEPTH = 128,
  parameter int unsigned CQ_DEPTH   = 4,
  parameter int unsigned DCNT_W     = 8,
  localparam int unsigned STRB_W    = DATA_W / 8,
  localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1),
  localparam int unsigned HALF_BIT  = $clog2(DATA_W / 16)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_narrow,
  input  logic              cfg_secure,
  input  logic              aw_valid,
  output logic              aw_ready,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic [LEN_W-1:0]  aw_len,
  input  logic [3:0]        aw_cache,
  input  logic [2:0]        aw_prot,
  input  logic              w_valid,
  output logic              w_ready,
  input  logic [DATA_W-1:0] w_data,
  input  logic [STRB_W-1:0] w_strb,
  input  logic              w_last,
  output logic              b_valid,
  input  logic              b_ready,
  output logic [1:0]        b_resp,
  output logic [CNT_W-1:0]  fifo_count,
  output logic              pop_valid,
  input  logic              pop_ready,
  output logic [DATA_W-1:0] pop_data,
  output logic [STRB_W-1:0] pop_strb
);
  // named internal events
  logic              aw_fire, w_fire, last_fire, b_fire;
  logic              fifo_room, cq_full, cur_known, resp_avail;
  logic              push;
  logic [DATA_W-1:0] push_data;
  logic [STRB_W-1:0] push_strb;
  wa_cmd_t           new_cmd, cur_cmd, head_cmd;
  logic              unused_fields;

  assign unused_fields = ^{aw_addr[ADDR_W-1:HALF_BIT+1], aw_addr[HALF_BIT-1:0],
                           aw_cache[3:2], aw_cache[0], aw_prot[2], aw_prot[0]};

  assign fifo_room = (fifo_count < CNT_W'(FIFO_DEPTH));
  assign w_ready   = fifo_room && (!cfg_narrow || cur_known);
  assign aw_ready  = !cq_full;
  assign aw_fire   = aw_valid && aw_ready;
  assign w_fire    = w_valid && w_ready;
  assign last_fire = w_fire && w_last;
  assign b_valid   = resp_avail;
  assign b_fire    = b_valid && b_ready;
  assign b_resp    = resp_for(head_cmd.reject);

  always_comb begin
    new_cmd.len      = aw_len;
    new_cmd.start_hi = aw_addr[HALF_BIT];
    new_cmd.pack     = aw_cache[1];
    new_cmd.reject   = refuse(cfg_secure, aw_prot);
  end

  wa_cmd_queue #(.DEPTH(CQ_DEPTH), .DCNT_W(DCNT_W)) u_cmdq (
    .clk(clk), .rst_n(rst_n),
    .push(aw_fire), .push_cmd(new_cmd),
    .data_done(last_fire), .resp_pop(b_fire),
    .full(cq_full), .cur_known(cur_known), .cur_cmd(cur_cmd),
    .resp_avail(resp_avail), .head_cmd(head_cmd)
  );

  wa_beat_packer #(.DATA_W(DATA_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .narrow(cfg_narrow),
    .beat_fire(w_fire), .w_data(w_data), .w_strb(w_strb), .w_last(w_last),
    .cur_known(cur_known), .cur_cmd(cur_cmd),
    .push(push), .push_data(push_data), .push_strb(push_strb)
  );

  wa_data_fifo #(.DEPTH(FIFO_DEPTH), .DW(DATA_W), .SW(STRB_W)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_data(push_data), .push_strb(push_strb),
    .pop_ready(pop_ready), .pop_valid(pop_valid),
    .pop_data(pop_data), .pop_strb(pop_strb), .count(fifo_count)
  );

  AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && !b_ready) |=> (b_valid && $stable(b_resp)));  // R6
  AST_SAME_CYCLE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_narrow && aw_fire && !cur_known) |-> !w_ready);  // R2
  AST_FULL_STOPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count == CNT_W'(FIFO_DEPTH)) |-> !w_fire);  // R1
endmodule

// File: tb/wr_width_adapt_tb.sv
module wr_width_adapt_tb;
  localparam int DEPTH = 128;
  localparam int CQD   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_narrow = 1'b0, cfg_secure = 1'b0;
  logic aw_valid = 1'b0, aw_ready;
  logic [31:0] aw_addr = '0;
  logic [3:0]  aw_len = '0, aw_cache = '0;
  logic [2:0]  aw_prot = '0;
  logic w_valid = 1'b0, w_ready, w_last = 1'b0;
  logic [63:0] w_data = '0;
  logic [7:0]  w_strb = '0;
  logic b_valid, b_ready = 1'b0;
  logic [1:0] b_resp;
  logic [7:0] fifo_count;
  logic pop_valid, pop_ready = 1'b0;
  logic [63:0] pop_data;
  logic [7:0]  pop_strb;

  always #5 clk = ~clk;

  wr_width_adapt u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_narrow(cfg_narrow), .cfg_secure(cfg_secure),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr), .aw_len(aw_len),
    .aw_cache(aw_cache), .aw_prot(aw_prot),
    .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_strb(w_strb), .w_last(w_last),
    .b_valid(b_valid), .b_ready(b_ready), .b_resp(b_resp),
    .fifo_count(fifo_count), .pop_valid(pop_valid), .pop_ready(pop_ready),
    .pop_data(pop_data), .pop_strb(pop_strb)
  );

  typedef struct { logic [31:0] addr; logic [3:0] len; logic [3:0] cache; logic [2:0] prot; int dly; } aw_item_t;
  typedef struct { logic [63:0] d; logic [7:0] s; logic last; int dly; } w_item_t;
  typedef struct { bit hi0; bit pack; bit rej; } m_cmd_t;

  aw_item_t aw_q[$];
  w_item_t  w_q[$];
  int tests = 0, fails = 0, base = 0;
  int pop_mode = 0, b_mode = 0;   // 0 always, 1 never, 2 pseudo-random
  int decerr_seen = 0, okay_seen = 0;
  bit engine_on = 0, done = 0;
  logic [15:0] lfsr = 16'hACE1;

  // reference model state
  m_cmd_t      m_cq[$];
  logic [63:0] m_fd[$];
  logic [7:0]  m_fs[$];
  int          m_dcnt = 0, m_bidx = 0;
  bit          m_hv = 0;
  logic [31:0] m_hd = '0;
  logic [3:0]  m_hs = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic add_burst(input logic [31:0] addr, input int len, input logic [3:0] cache,
                           input logic [2:0] prot, input int adly, input int wdly);
    aw_item_t a;
    a.addr = addr; a.len = 4'(len); a.cache = cache; a.prot = prot; a.dly = adly;
    aw_q.push_back(a);
    for (int k = 0; k <= len; k++) begin
      w_item_t w;
      w.d = {32'hC0DE0000 + 32'(base * 16 + k), 32'h51000000 + 32'(base * 16 + k)};
      w.s = (k % 2 == 1) ? 8'hA3 : 8'h5F ^ 8'(k << 4);
      w.last = (k == len);
      w.dly = (k == 0) ? wdly : 0;
      w_q.push_back(w);
    end
    base++;
  endtask

  // per-cycle engine: drive at negedge, compare, advance model
  initial begin : engine
    bit awf_prev = 0, wf_prev = 0;
    wait (engine_on);
    forever begin
      @(negedge clk);
      if (awf_prev) begin void'(aw_q.pop_front()); aw_valid = 1'b0; end
      if (wf_prev)  begin void'(w_q.pop_front());  w_valid  = 1'b0; end
      if (!aw_valid && aw_q.size() > 0) begin
        if (aw_q[0].dly > 0) aw_q[0].dly = aw_q[0].dly - 1;
        else begin
          aw_valid = 1'b1; aw_addr = aw_q[0].addr; aw_len = aw_q[0].len;
          aw_cache = aw_q[0].cache; aw_prot = aw_q[0].prot;
        end
      end
      if (!w_valid && w_q.size() > 0) begin
        if (w_q[0].dly > 0) w_q[0].dly = w_q[0].dly - 1;
        else begin
          w_valid = 1'b1; w_data = w_q[0].d; w_strb = w_q[0].s; w_last = w_q[0].last;
        end
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pop_ready = (pop_mode == 0) ? 1'b1 : (pop_mode == 1) ? 1'b0 : lfsr[0];
      b_ready   = (b_mode == 0) ? 1'b1 : (b_mode == 1) ? 1'b0 : lfsr[3];
      #1;
      begin
        bit known, e_awr, e_wr, e_bv, e_pv, wf, awf, bf, pf, push;
        m_cmd_t cur;
        logic [63:0] ed;
        logic [7:0] es;
        known = (m_dcnt < m_cq.size());
        if (known) cur = m_cq[m_dcnt]; else cur = '{0, 0, 0};
        e_awr = (m_cq.size() < CQD);
        e_wr  = (m_fd.size() < DEPTH) && (!cfg_narrow || known);
        e_bv  = (m_cq.size() > 0) && (m_dcnt > 0);
        e_pv  = (m_fd.size() > 0);
        chk(aw_ready == e_awr, "R8 aw_ready", 64'(aw_ready), 64'(e_awr));
        if (cfg_narrow) chk(w_ready == e_wr, "R2 w_ready narrow", 64'(w_ready), 64'(e_wr));
        else            chk(w_ready == e_wr, "R1 w_ready wide", 64'(w_ready), 64'(e_wr));
        chk(fifo_count == 8'(m_fd.size()), "R5 fifo_count", 64'(fifo_count), 64'(m_fd.size()));
        chk(pop_valid == e_pv, "R5 pop_valid", 64'(pop_valid), 64'(e_pv));
        chk(b_valid == e_bv, "R6 b_valid", 64'(b_valid), 64'(e_bv));
        if (e_bv) chk(b_resp == (m_cq[0].rej ? 2'b11 : 2'b00), "R6 b_resp",
                      64'(b_resp), 64'(m_cq[0].rej ? 2'b11 : 2'b00));
        if (e_pv) begin
          chk(pop_data == m_fd[0], "R3 R4 pop_data", pop_data, m_fd[0]);
          chk(pop_strb == m_fs[0], "R3 R4 R7 pop_strb", 64'(pop_strb), 64'(m_fs[0]));
        end
        awf = aw_valid && e_awr;
        wf  = w_valid && e_wr;
        bf  = e_bv && b_ready;
        pf  = e_pv && pop_ready;
        push = 0; ed = '0; es = '0;
        if (wf) begin
          if (!cfg_narrow) begin
            push = 1; ed = w_data; es = w_strb;
          end else begin
            bit hi;
            hi = cur.hi0 ^ (m_bidx % 2 == 1);
            if (cur.pack) begin
              if (!hi && !w_last) begin
                m_hv = 1; m_hd = w_data[31:0]; m_hs = w_strb[3:0];
              end else if (hi) begin
                push = 1;
                ed = {w_data[31:0], m_hv ? m_hd : 32'h0};
                es = {w_strb[3:0], m_hv ? m_hs : 4'h0};
                m_hv = 0;
              end else begin
                push = 1; ed = {32'h0, w_data[31:0]}; es = {4'h0, w_strb[3:0]}; m_hv = 0;
              end
            end else begin
              push = 1;
              ed = hi ? {w_data[31:0], 32'h0} : {32'h0, w_data[31:0]};
              es = hi ? {w_strb[3:0], 4'h0} : {4'h0, w_strb[3:0]};
            end
          end
          if (known && cur.rej) es = '0;
          m_bidx = w_last ? 0 : m_bidx + 1;
        end
        if (pf) begin void'(m_fd.pop_front()); void'(m_fs.pop_front()); end
        if (push) begin m_fd.push_back(ed); m_fs.push_back(es); end
        if (bf) begin
          if (m_cq[0].rej) decerr_seen++; else okay_seen++;
          void'(m_cq.pop_front()); m_dcnt--;
        end
        if (wf && w_last) m_dcnt++;
        if (awf) m_cq.push_back('{aw_addr[2], aw_cache[1], cfg_secure & aw_prot[1]});
        awf_prev = awf; wf_prev = wf;
      end
    end
  end

  task automatic wait_idle();
    int guard = 0;
    while (guard < 5000 && !(aw_q.size() == 0 && w_q.size() == 0 && !aw_valid && !w_valid &&
           m_cq.size() == 0 && m_fd.size() == 0)) begin
      @(posedge clk); guard++;
    end
    chk(guard < 5000, "R5 drain", 64'(guard), 64'(0));
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL R5 watchdog actual=%h expected=%h", 64'(1), 64'(0));
      finish_run();
    end
  end

  initial begin : scenario
    int d0, o0;
    repeat (3) @(posedge clk);
    #1;
    chk(fifo_count == 0, "R9 reset count", 64'(fifo_count), 64'(0));
    chk(!pop_valid && !b_valid, "R9 reset valids", 64'({pop_valid, b_valid}), 64'(0));
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(aw_ready == 1'b1, "R9 aw_ready after reset", 64'(aw_ready), 64'(1));
    engine_on = 1;

    // 64-bit mode, secure port, mixed protection, data before address once
    cfg_narrow = 0; cfg_secure = 1; pop_mode = 2; b_mode = 2;
    d0 = decerr_seen; o0 = okay_seen;
    add_burst(32'h1000, 3, 4'h2, 3'b000, 5, 0);
    add_burst(32'h2000, 2, 4'h0, 3'b010, 0, 0);
    add_burst(32'h3000, 0, 4'h2, 3'b011, 0, 2);
    add_burst(32'h4000, 5, 4'h2, 3'b000, 0, 0);
    wait_idle();
    chk(decerr_seen - d0 == 2, "R6 decode errors wide", 64'(decerr_seen - d0), 64'(2));
    chk(okay_seen - o0 == 2, "R6 okay wide", 64'(okay_seen - o0), 64'(2));

    // 32-bit upsizing: aligned, odd start, single beat, same-cycle address
    cfg_narrow = 1; pop_mode = 2;
    add_burst(32'h0100, 3, 4'h2, 3'b000, 0, 0);
    add_burst(32'h0204, 2, 4'h3, 3'b000, 0, 3);
    add_burst(32'h0300, 0, 4'h2, 3'b000, 0, 2);
    add_burst(32'h0408, 4, 4'h2, 3'b000, 0, 1);
    add_burst(32'h050C, 0, 4'h2, 3'b000, 0, 0);
    wait_idle();

    // 32-bit expansion and a refused burst
    cfg_secure = 1; b_mode = 0;
    d0 = decerr_seen;
    add_burst(32'h0600, 3, 4'h0, 3'b000, 0, 2);
    add_burst(32'h0704, 2, 4'h1, 3'b010, 0, 2);
    add_burst(32'h0804, 1, 4'h2, 3'b010, 0, 1);
    wait_idle();
    chk(decerr_seen - d0 == 2, "R7 refused bursts answered", 64'(decerr_seen - d0), 64'(2));
    cfg_secure = 0;
    d0 = decerr_seen;
    add_burst(32'h0900, 1, 4'h0, 3'b010, 0, 1);
    wait_idle();
    chk(decerr_seen == d0, "R6 open port okay", 64'(decerr_seen - d0), 64'(0));

    // same-cycle address and first beat in 32-bit mode: one wait cycle
    @(negedge clk);
    add_burst(32'h0A00, 1, 4'h0, 3'b000, 0, 0);
    @(negedge clk); #2;
    chk(w_valid && !w_ready, "R2 wait cycle", 64'({w_valid, w_ready}), 64'(2'b10));
    @(negedge clk); #2;
    chk(w_ready == 1'b1, "R2 ready after address", 64'(w_ready), 64'(1));
    wait_idle();

    // 64-bit fill to the limit with the consumer stalled
    cfg_narrow = 0; pop_mode = 1; b_mode = 0;
    for (int i = 0; i < 9; i++) add_burst(32'h8000 + 32'(i * 128), 15, 4'h2, 3'b000, 0, 0);
    begin
      int g = 0;
      while (fifo_count != 8'(DEPTH) && g < 2000) begin @(posedge clk); g++; end
    end
    repeat (3) @(negedge clk);
    #2;
    chk(fifo_count == 8'(DEPTH), "R5 full count", 64'(fifo_count), 64'(DEPTH));
    chk(w_valid && !w_ready, "R1 ready low at limit", 64'({w_valid, w_ready}), 64'(2'b10));
    pop_mode = 0;
    wait_idle();

    // command queue limit
    b_mode = 1;
    for (int i = 0; i < 6; i++) add_burst(32'h9000 + 32'(i * 64), 1, 4'h2, 3'b000, 0, (i == 0) ? 4 : 0);
    repeat (12) @(negedge clk);
    #2;
    chk(aw_valid && !aw_ready, "R8 queue full", 64'({aw_valid, aw_ready}), 64'(2'b10));
    b_mode = 0;
    wait_idle();

    done = 1;
    finish_run();
  end
endmodule